// File: doc/BRIEF.md
# Impulse-Radio Frame Pulse Modulator

This block produces the slot-by-slot pulse commands for an impulse-radio ultra-wideband transmitter. There is one slot per clock. In every slot it drives a pair of bits: one asks the analogue front end for a pulse and the other chooses that pulse's sign. The front end therefore sees three line states: positive pulse, negative pulse, or nothing.

A frame is started by a strobe. It is made of three parts, in this order:

- a synchronisation header, which repeats a ternary spreading code a selectable number of times;
- a delimiter of eight code periods, each multiplied by a fixed ternary pattern;
- the payload, taken from a byte stream under a ready/valid handshake.

Every payload symbol carries two bits. The first bit places a short pulse burst in the early or late half of the symbol. The second bit sets the sign of the whole burst. That sign is further scrambled pulse by pulse by a pseudo-noise shift register, which is seeded when the frame starts.

Top module: `uwb_burst_modulator`

## Requirements
- R1: Line encoding. `pulse_en`=1 with `pulse_pol`=0 is a positive pulse. `pulse_en`=1 with `pulse_pol`=1 is a negative pulse. `pulse_pol` is 0 whenever `pulse_en` is 0.
- R2: A `start` sampled high while idle begins the frame. The first header slot appears in the cycle after that clock edge, and `pre_sel` and `seed` are captured on that edge. A `start` while `busy` is high has no effect.
- R3: A code period is 31 elements, element 0 first, and each element occupies 16 slots (496 slots per period). Only the first slot of an element can carry a pulse. That pulse is present when the element is nonzero and negative when the element is -1.
- R4: `pre_sel` values 0, 1, 2 and 3 select 16, 64, 1024 and 4096 header code periods.
- R5: The delimiter follows the header with no gap and lasts eight code periods, entry 0 first. Entry q multiplies every element of period q: a 0 entry removes the pulses and a -1 entry inverts them.
- R6: `in_ready` is high in three kinds of slot: the final delimiter slot, the final slot of the fourth symbol of a byte that was not flagged last, and every wait slot. A byte transfers when `in_ready` and `in_valid` are both high at a clock edge, and its first symbol begins in the next slot.
- R7: If no byte is offered when one is due, the block emits empty slots with `busy` high and `in_ready` high until a byte arrives.
- R8: Each byte forms four symbols, least significant pair first. For symbol k, bit 2k is the position bit and bit 2k+1 is the sign bit.
- R9: A symbol is 512 slots. The burst is 16 consecutive pulses, starting at symbol slot 0 when the position bit is 0 and at slot 256 when it is 1. No other slot of the symbol has a pulse.
- R10: The polarity of each burst pulse is the sign bit XOR the scrambler output. The scrambler is a 15-bit register whose output is its MSB and which shifts left taking bit14 XOR bit13. It steps after each burst pulse, is loaded from `seed` at start, and is loaded with 1 when `seed` is zero.
- R11: After the fourth symbol of the byte marked by `in_last` ends, `busy` falls in the next slot and the outputs stay quiet.
- R12: After reset `busy`, `in_ready`, `pulse_en` and `pulse_pol` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start strobe |
| pre_sel | input | 2 | Header length selection |
| seed | input | 15 | Scrambler seed |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte offered |
| in_last | input | 1 | Offered byte is the final one |
| in_ready | output | 1 | Block accepts a byte this slot |
| pulse_en | output | 1 | Pulse request for this slot |
| pulse_pol | output | 1 | Pulse sign, 1 = negative |
| busy | output | 1 | Frame in progress |

## Verification
The properties assume the following about the source:

- it holds `in_valid`, `in_data` and `in_last` steady from one clock edge to the next;
- it marks the last byte of a frame with `in_last`;
- it never asks for a transfer outside a slot in which `in_ready` is high.

The stimulus drives all inputs on the falling edge. It raises `in_valid` only in slots where the reference model predicts `in_ready`, and drops it right after the accepting edge.

The sweep covers:

- the two shortest header lengths;
- a zero and a nonzero seed;
- seamless byte hand-offs and stalled ones;
- a stray `start` inside the header.

The header and delimiter code values and the position and sign bit pairs are all computed in the bench from the requirement text.

// File: rtl/uwb_mod_pkg.sv
package uwb_mod_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_HDR  = 3'd1,
      PH_DLM  = 3'd2,
      PH_WAIT = 3'd3,
      PH_SYM  = 3'd4
   } phase_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int width_for(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/uwb_pn_lfsr.sv
module uwb_pn_lfsr #(
   parameter int               W    = 15,
   parameter logic [W-1:0]     TAPS = 15'h6000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         step,
   output logic         out_bit
);

   logic [W-1:0] st;
   logic [W-1:0] tapped;
   logic         fb;

   for (genvar gi = 0; gi < W; gi++) begin : g_tap
      if (TAPS[gi]) begin : g_on
         assign tapped[gi] = st[gi];
      end else begin : g_off
         assign tapped[gi] = 1'b0;
      end
   end

   assign fb      = ^tapped;
   assign out_bit = st[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= W'(1);
      end else if (load) begin
         st <= (seed == '0) ? W'(1) : seed;
      end else if (step) begin
         st <= {st[W-2:0], fb};
      end
   end

endmodule

// File: rtl/uwb_code_lookup.sv
module uwb_code_lookup #(
   parameter int                  CODE_LEN = 31,
   parameter logic [CODE_LEN-1:0] CODE_NZ  = '1,
   parameter logic [CODE_LEN-1:0] CODE_NEG = '0,
   parameter int                  DLM_LEN  = 8,
   parameter logic [DLM_LEN-1:0]  DLM_NZ   = '1,
   parameter logic [DLM_LEN-1:0]  DLM_NEG  = '0,
   localparam int                 CODE_W   = uwb_mod_pkg::width_for(CODE_LEN),
   localparam int                 DLM_W    = uwb_mod_pkg::width_for(DLM_LEN)
) (
   input  logic [CODE_W-1:0] elem,
   input  logic [DLM_W-1:0]  dlm_idx,
   input  logic              in_dlm,
   output logic              nz,
   output logic              neg
);

   logic e_nz, e_neg, d_nz, d_neg;

   always_comb begin
      e_nz  = CODE_NZ[elem];
      e_neg = CODE_NEG[elem];
      d_nz  = in_dlm ? DLM_NZ[dlm_idx]  : 1'b1;
      d_neg = in_dlm ? DLM_NEG[dlm_idx] : 1'b0;
      nz    = e_nz & d_nz;
      neg   = nz & (e_neg ^ d_neg);
   end

endmodule

// File: rtl/uwb_frame_seq.sv
module uwb_frame_seq
   import uwb_mod_pkg::*;
#(
   parameter int  SPREAD    = 16,
   parameter int  CODE_LEN  = 31,
   parameter int  DLM_LEN   = 8,
   parameter int  HDR_LEN0  = 16,
   parameter int  HDR_LEN1  = 64,
   parameter int  HDR_LEN2  = 1024,
   parameter int  HDR_LEN3  = 4096,
   parameter int  SYM_SLOTS = 512,
   parameter int  BYTE_W    = 8,
   localparam int SPREAD_W  = width_for(SPREAD),
   localparam int CODE_W    = width_for(CODE_LEN),
   localparam int HDR_MAX   = max_of(max_of(HDR_LEN0, HDR_LEN1), max_of(HDR_LEN2, HDR_LEN3)),
   localparam int CNT_W     = width_for(max_of(HDR_MAX, DLM_LEN)),
   localparam int SYM_W     = width_for(SYM_SLOTS),
   localparam int SPB       = BYTE_W / 2,
   localparam int SPB_W     = width_for(SPB)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [1:0]          hdr_sel,
   input  logic [BYTE_W-1:0]   in_data,
   input  logic                in_valid,
   input  logic                in_last,
   output logic                in_ready,
   output phase_t              phase,
   output logic [SPREAD_W-1:0] slot,
   output logic [CODE_W-1:0]   elem,
   output logic [CNT_W-1:0]    per_cnt,
   output logic [SYM_W-1:0]    sym_slot,
   output logic                pos_bit,
   output logic                sgn_bit
);

   localparam logic [SPREAD_W-1:0] SLOT_LAST = SPREAD_W'(SPREAD - 1);
   localparam logic [CODE_W-1:0]   ELEM_LAST = CODE_W'(CODE_LEN - 1);
   localparam logic [CNT_W-1:0]    DLM_LAST  = CNT_W'(DLM_LEN - 1);
   localparam logic [SYM_W-1:0]    SYM_LAST  = SYM_W'(SYM_SLOTS - 1);
   localparam logic [SPB_W-1:0]    SPB_LAST  = SPB_W'(SPB - 1);

   logic [CNT_W-1:0]  hdr_last;
   logic [CNT_W-1:0]  hdr_last_sel;
   logic [BYTE_W-1:0] shreg;
   logic              cur_last;
   logic [SPB_W-1:0]  sym_idx;
   logic              period_end;
   logic              dlm_end;
   logic              sym_end;

   always_comb begin
      case (hdr_sel)
         2'd0:    hdr_last_sel = CNT_W'(HDR_LEN0 - 1);
         2'd1:    hdr_last_sel = CNT_W'(HDR_LEN1 - 1);
         2'd2:    hdr_last_sel = CNT_W'(HDR_LEN2 - 1);
         default: hdr_last_sel = CNT_W'(HDR_LEN3 - 1);
      endcase
   end

   assign period_end = (slot == SLOT_LAST) && (elem == ELEM_LAST);
   assign dlm_end    = (phase == PH_DLM) && period_end && (per_cnt == DLM_LAST);
   assign sym_end    = (phase == PH_SYM) && (sym_slot == SYM_LAST) && (sym_idx == SPB_LAST);
   assign in_ready   = dlm_end || (phase == PH_WAIT) || (sym_end && !cur_last);
   assign pos_bit    = shreg[0];
   assign sgn_bit    = shreg[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         slot     <= '0;
         elem     <= '0;
         per_cnt  <= '0;
         hdr_last <= '0;
         sym_slot <= '0;
         sym_idx  <= '0;
         shreg    <= '0;
         cur_last <= 1'b0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase    <= PH_HDR;
                  slot     <= '0;
                  elem     <= '0;
                  per_cnt  <= '0;
                  hdr_last <= hdr_last_sel;
               end
            end
            PH_HDR, PH_DLM: begin
               if (slot == SLOT_LAST) begin
                  slot <= '0;
                  if (elem == ELEM_LAST) begin
                     elem <= '0;
                     if (phase == PH_HDR && per_cnt == hdr_last) begin
                        per_cnt <= '0;
                        phase   <= PH_DLM;
                     end else begin
                        per_cnt <= per_cnt + 1'b1;
                     end
                  end else begin
                     elem <= elem + 1'b1;
                  end
               end else begin
                  slot <= slot + 1'b1;
               end
            end
            PH_SYM: begin
               if (sym_slot == SYM_LAST) begin
                  sym_slot <= '0;
                  shreg    <= shreg >> 2;
                  if (sym_idx == SPB_LAST) begin
                     sym_idx <= '0;
                     if (cur_last) phase <= PH_IDLE;
                  end else begin
                     sym_idx <= sym_idx + 1'b1;
                  end
               end else begin
                  sym_slot <= sym_slot + 1'b1;
               end
            end
            default: ;
         endcase

         // byte fetch overrides the plain counting above
         if (in_ready) begin
            if (in_valid) begin
               phase    <= PH_SYM;
               shreg    <= in_data;
               cur_last <= in_last;
               sym_slot <= '0;
               sym_idx  <= '0;
            end else begin
               phase <= PH_WAIT;
            end
         end
      end
   end

endmodule

// File: rtl/uwb_burst_modulator.sv
module uwb_burst_modulator
   import uwb_mod_pkg::*;
#(
   parameter int                  SPREAD    = 16,
   parameter int                  CODE_LEN  = 31,
   parameter logic [CODE_LEN-1:0] CODE_NZ   = 31'h2AF31D6B,
   parameter logic [CODE_LEN-1:0] CODE_NEG  = 31'h2AF31D6B & 31'h12345678,
   parameter int                  DLM_LEN   = 8,
   parameter logic [DLM_LEN-1:0]  DLM_NZ    = 8'b1001_1010,
   parameter logic [DLM_LEN-1:0]  DLM_NEG   = 8'b1000_1000,
   parameter int                  HDR_LEN0  = 16,
   parameter int                  HDR_LEN1  = 64,
   parameter int                  HDR_LEN2  = 1024,
   parameter int                  HDR_LEN3  = 4096,
   parameter int                  SYM_SLOTS = 512,
   parameter int                  BURST_LEN = 16,
   parameter int                  PN_W      = 15,
   parameter logic [PN_W-1:0]     PN_TAPS   = 15'h6000,
   parameter int                  BYTE_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        pre_sel,
   input  logic [PN_W-1:0]   seed,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_last,
   output logic              in_ready,
   output logic              pulse_en,
   output logic              pulse_pol,
   output logic              busy
);

   localparam int SPREAD_W = width_for(SPREAD);
   localparam int CODE_W   = width_for(CODE_LEN);
   localparam int DLM_W    = width_for(DLM_LEN);
   localparam int HDR_MAX  = max_of(max_of(HDR_LEN0, HDR_LEN1), max_of(HDR_LEN2, HDR_LEN3));
   localparam int CNT_W    = width_for(max_of(HDR_MAX, DLM_LEN));
   localparam int SYM_W    = width_for(SYM_SLOTS);
   localparam logic [SYM_W-1:0] HALF  = SYM_W'(SYM_SLOTS / 2);
   localparam logic [SYM_W-1:0] BURST = SYM_W'(BURST_LEN);

   if (SPREAD < 2) begin : g_bad_spread
      $error("SPREAD must be at least 2");
   end
   if ((SYM_SLOTS % 2) != 0 || BURST_LEN < 1 || BURST_LEN > SYM_SLOTS / 2) begin : g_bad_sym
      $error("burst must fit inside half a symbol");
   end
   if ((BYTE_W % 2) != 0 || BYTE_W < 4) begin : g_bad_byte
      $error("BYTE_W must be even and at least 4");
   end
   if ((CODE_NEG & ~CODE_NZ) != '0 || (DLM_NEG & ~DLM_NZ) != '0) begin : g_bad_code
      $error("negative marks must sit on nonzero entries");
   end
   if (PN_W < 2 || PN_TAPS[PN_W-1] == 1'b0) begin : g_bad_pn
      $error("scrambler needs its top tap");
   end

   phase_t              phase;
   logic [SPREAD_W-1:0] slot;
   logic [CODE_W-1:0]   elem;
   logic [CNT_W-1:0]    per_cnt;
   logic [SYM_W-1:0]    sym_slot;
   logic                pos_bit, sgn_bit;
   logic                code_nz, code_neg;
   logic                pn_bit;
   logic                in_code, code_pulse, in_burst;
   logic [SYM_W-1:0]    base, off;

   uwb_frame_seq #(
      .SPREAD(SPREAD), .CODE_LEN(CODE_LEN), .DLM_LEN(DLM_LEN),
      .HDR_LEN0(HDR_LEN0), .HDR_LEN1(HDR_LEN1), .HDR_LEN2(HDR_LEN2), .HDR_LEN3(HDR_LEN3),
      .SYM_SLOTS(SYM_SLOTS), .BYTE_W(BYTE_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .hdr_sel(pre_sel),
      .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
      .phase(phase), .slot(slot), .elem(elem), .per_cnt(per_cnt),
      .sym_slot(sym_slot), .pos_bit(pos_bit), .sgn_bit(sgn_bit)
   );

   uwb_code_lookup #(
      .CODE_LEN(CODE_LEN), .CODE_NZ(CODE_NZ), .CODE_NEG(CODE_NEG),
      .DLM_LEN(DLM_LEN), .DLM_NZ(DLM_NZ), .DLM_NEG(DLM_NEG)
   ) u_code (
      .elem(elem), .dlm_idx(per_cnt[DLM_W-1:0]), .in_dlm(phase == PH_DLM),
      .nz(code_nz), .neg(code_neg)
   );

   uwb_pn_lfsr #(.W(PN_W), .TAPS(PN_TAPS)) u_pn (
      .clk(clk), .rst_n(rst_n), .load(phase == PH_IDLE && start), .seed(seed),
      .step(in_burst), .out_bit(pn_bit)
   );

   always_comb begin
      in_code    = (phase == PH_HDR) || (phase == PH_DLM);
      code_pulse = in_code && (slot == '0) && code_nz;
      base       = pos_bit ? HALF : '0;
      off        = sym_slot - base;
      in_burst   = (phase == PH_SYM) && (sym_slot >= base) && (off < BURST);
      pulse_en   = code_pulse || in_burst;
      pulse_pol  = code_pulse ? code_neg : (in_burst && (sgn_bit ^ pn_bit));
      busy       = (phase != PH_IDLE);
   end

endmodule

// File: rtl/uwb_burst_modulator_chk.sv
module uwb_burst_modulator_chk
   import uwb_mod_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   start,
   input logic   busy,
   input logic   pulse_en,
   input logic   pulse_pol,
   input logic   in_ready,
   input logic   in_valid,
   input phase_t phase
);

   a_r1_pol_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_en |-> !pulse_pol);

   a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   a_r3_sparse_code: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_HDR || phase == PH_DLM) && pulse_en) |=> !pulse_en);

   a_r6_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> busy);

   a_r6_transfer_to_symbol: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && in_valid) |=> (phase == PH_SYM));

   a_r7_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT) |-> (in_ready && !pulse_en));

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!pulse_en && !in_ready));

endmodule

bind uwb_burst_modulator uwb_burst_modulator_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
   .pulse_en(pulse_en), .pulse_pol(pulse_pol), .in_ready(in_ready),
   .in_valid(in_valid), .phase(phase)
);

// File: tb/uwb_burst_modulator_test.sv
module uwb_burst_modulator_test;

   localparam logic [30:0] T_NZ   = 31'h2AF31D6B;
   localparam logic [30:0] T_NEG  = 31'h2AF31D6B & 31'h12345678;
   localparam logic [7:0]  T_DNZ  = 8'b1001_1010;
   localparam logic [7:0]  T_DNEG = 8'b1000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  pre_sel = 2'd0;
   logic [14:0] seed = '0;
   logic [7:0]  in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_last = 1'b0;
   logic        in_ready, pulse_en, pulse_pol, busy;

   int n_checks = 0;
   int n_err    = 0;
   int slot_no  = 0;
   bit done     = 1'b0;

   logic [7:0]  fr_bytes [4];
   int          fr_gaps  [4];
   logic [14:0] m;

   always #4 clk = ~clk;

   uwb_burst_modulator #(
      .CODE_NZ(T_NZ), .CODE_NEG(T_NEG), .DLM_NZ(T_DNZ), .DLM_NEG(T_DNEG)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .pre_sel(pre_sel), .seed(seed),
      .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
      .pulse_en(pulse_en), .pulse_pol(pulse_pol), .busy(busy)
   );

   task automatic chk_slot(input logic e_en, input logic e_pol, input logic e_busy,
                           input logic e_rdy, input string tag);
      n_checks++;
      if ({pulse_en, pulse_pol, busy, in_ready} !== {e_en, e_pol, e_busy, e_rdy}) begin
         n_err++;
         $display("FAIL %s slot %0d en/pol/busy/rdy got %b%b%b%b expected %b%b%b%b",
                  tag, slot_no, pulse_en, pulse_pol, busy, in_ready,
                  e_en, e_pol, e_busy, e_rdy);
      end
      slot_no++;
      @(negedge clk);
   endtask

   function automatic int hdr_len(input logic [1:0] s);
      case (s)
         2'd0:    return 16;
         2'd1:    return 64;
         2'd2:    return 1024;
         default: return 4096;
      endcase
   endfunction

   task automatic offer(input int i, input int nb);
      in_data  = fr_bytes[i];
      in_last  = (i == nb - 1);
      in_valid = 1'b1;
   endtask

   task automatic run_frame(input logic [1:0] sel, input logic [14:0] sd,
                            input int nb, input bit poke);
      int  p;
      logic en, pol, lst, rdy;
      logic [7:0] bt;
      m = (sd == '0) ? 15'd1 : sd;       // R10 zero seed
      slot_no = 0;
      start = 1'b1; pre_sel = sel; seed = sd;
      @(negedge clk);
      start = 1'b0; pre_sel = ~sel; seed = ~sd;   // R2 values are captured
      p = hdr_len(sel);
      for (int s = 0; s < p; s++)
         for (int e = 0; e < 31; e++)
            for (int k = 0; k < 16; k++) begin
               if (poke && s == 1 && e == 0 && k == 3) start = 1'b1;
               en  = (k == 0) && T_NZ[e];
               pol = en && T_NEG[e];
               chk_slot(en, pol, 1'b1, 1'b0, poke && s >= 1 ? "R2/R4" : "R1/R3");
               start = 1'b0;
            end
      for (int q = 0; q < 8; q++)
         for (int e = 0; e < 31; e++)
            for (int k = 0; k < 16; k++) begin
               lst = (q == 7) && (e == 30) && (k == 15);
               if (lst && fr_gaps[0] == 0) offer(0, nb);
               en  = (k == 0) && T_NZ[e] && T_DNZ[q];
               pol = en && (T_NEG[e] ^ T_DNEG[q]);
               chk_slot(en, pol, 1'b1, lst, lst ? "R6" : "R5");
               if (lst) in_valid = 1'b0;
            end
      for (int i = 0; i < nb; i++) begin
         for (int w = 0; w < fr_gaps[i]; w++) begin
            if (w == fr_gaps[i] - 1) offer(i, nb);
            chk_slot(1'b0, 1'b0, 1'b1, 1'b1, "R7");
            in_valid = 1'b0;
         end
         bt = fr_bytes[i];
         for (int y = 0; y < 4; y++) begin
            // R8: pair y of the byte, low bit = position, high bit = sign
            for (int t = 0; t < 512; t++) begin
               int base;
               base = bt[2*y] ? 256 : 0;
               en   = (t >= base) && (t < base + 16);
               pol  = en && (bt[2*y+1] ^ m[14]);
               rdy  = (y == 3) && (t == 511) && (i < nb - 1);
               if (rdy && fr_gaps[i+1] == 0) offer(i + 1, nb);
               chk_slot(en, pol, 1'b1, rdy, en ? "R8/R10" : "R8/R9");
               if (rdy) in_valid = 1'b0;
               if (en) m = {m[13:0], m[14] ^ m[13]};
            end
         end
      end
      chk_slot(1'b0, 1'b0, 1'b0, 1'b0, "R11");
      chk_slot(1'b0, 1'b0, 1'b0, 1'b0, "R11");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_slot(1'b0, 1'b0, 1'b0, 1'b0, "R12");
      rst_n = 1'b1;
      @(negedge clk);
      chk_slot(1'b0, 1'b0, 1'b0, 1'b0, "R12");

      fr_bytes[0] = 8'hA5; fr_bytes[1] = 8'h3C;
      fr_gaps[0]  = 0;     fr_gaps[1]  = 0;
      run_frame(2'd0, 15'h1ACE, 2, 1'b0);

      fr_bytes[0] = 8'h0F; fr_bytes[1] = 8'hF0; fr_bytes[2] = 8'h96;
      fr_gaps[0]  = 3;     fr_gaps[1]  = 0;     fr_gaps[2]  = 5;
      run_frame(2'd1, 15'h0000, 3, 1'b1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_checks++;
         $display("FAIL watchdog: run did not complete (all requirements)");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

endmodule